// File: doc/BRIEF.md
# Latched Cascadable Magnitude Comparator

This block compares two words, P and Q, and reports one of two decisions: P above Q, or Q above P. A mode input picks the number format at run time. With mode high both words are unsigned. With mode low both are two's-complement.

The P side has a hold register that can track the live input or keep an earlier word. While the track input is high, the comparison uses the live P word and the register follows it on every clock. While track is low, the comparison uses the word last captured. Reset clears the held word to zero.

Two cascade inputs carry the verdict of a less significant slice. When the two words are equal, the slice copies those inputs to its outputs, so slices chain into wider comparators. The least significant slice ties both cascade inputs low, and both outputs low then mean equality. Only the most significant slice of a chain uses signed mode; all lower slices compare unsigned.

Top module: `cascade_mag_cmp`

## Requirements
- R1: While `p_track` is high, the comparison uses the live `p_word`, and the held word takes `p_word` on each rising clock edge.
- R2: While `p_track` is low, the comparison uses the word held at the last rising edge at which `p_track` was high, whatever `p_word` does.
- R3: Reset (`rst_n` low) clears the held P word to zero.
- R4: `logical_mode` = 1 compares both words as unsigned numbers.
- R5: `logical_mode` = 0 compares both words as two's-complement numbers, with bit W-1 as the sign. This applies to every combination of sign bits.
- R6: When P is above Q in the selected mode, `gt_out` = 1 and `lt_out` = 0, whatever the cascade inputs are.
- R7: When Q is above P in the selected mode, `lt_out` = 1 and `gt_out` = 0, whatever the cascade inputs are.
- R8: When P equals Q, `gt_out` equals `gt_in` and `lt_out` equals `lt_in`.
- R9: Three slices chained least significant first, with the cascade inputs of the lowest slice at 0 and signed mode only on the top slice, give a correct 24-bit unsigned or signed comparison. Both outputs low means equality.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that updates the held P word |
| rst_n | input | 1 | Active-low asynchronous reset; clears the held word |
| p_word | input | W | Live P operand |
| q_word | input | W | Q operand |
| p_track | input | 1 | 1: use the live P and capture it; 0: use the held P |
| logical_mode | input | 1 | 1: unsigned comparison; 0: two's-complement comparison |
| gt_in | input | 1 | "Above" verdict from the less significant slice |
| lt_in | input | 1 | "Below" verdict from the less significant slice |
| gt_out | output | 1 | P above Q, or `gt_in` when the words are equal |
| lt_out | output | 1 | Q above P, or `lt_in` when the words are equal |

## Verification
The bench builds the slice only at the default width W = 8. At that width all four sign-bit pairs can be chosen by hand, including the most negative value against the most positive and equal magnitudes with opposite signs. Three more W = 8 instances form a 24-bit chain. Random signed and unsigned pairs on that chain, including pairs with equal upper bytes, make the cascade pass-through decide the result across slice boundaries.

// File: rtl/cascade_mag_cmp.sv
module cascade_mag_cmp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] p_word,
  input  logic [W-1:0] q_word,
  input  logic         p_track,
  input  logic         logical_mode,
  input  logic         gt_in,
  input  logic         lt_in,
  output logic         gt_out,
  output logic         lt_out
);
  localparam int MSB = W - 1;

  logic [W-1:0] p_held, p_eff, p_key, q_key;
  logic         p_above, q_above;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       p_held <= '0;
    else if (p_track) p_held <= p_word;

  assign p_eff = p_track ? p_word : p_held;

  // inverting the sign bit maps signed order onto unsigned order
  assign p_key = {p_eff[MSB]  ^ ~logical_mode, p_eff[MSB-1:0]};
  assign q_key = {q_word[MSB] ^ ~logical_mode, q_word[MSB-1:0]};

  assign p_above = p_key > q_key;
  assign q_above = q_key > p_key;

  assign gt_out = p_above | (~q_above & gt_in);
  assign lt_out = q_above | (~p_above & lt_in);

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> p_held == '0); // R3
  AST_TRACK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    p_track |=> p_held == $past(p_word)); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !p_track |=> $stable(p_held)); // R2
  AST_DECISION_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (p_eff != q_word) |-> (gt_out ^ lt_out)); // R6
  AST_EQ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (p_eff == q_word) |-> (gt_out == gt_in && lt_out == lt_in)); // R8
endmodule

// File: tb/cascade_mag_cmp_tb.sv
`timescale 1ns/1ps
module cascade_mag_cmp_tb;
  typedef struct {
    logic  gt;
    logic  lt;
    logic  chain;
    string tag;
  } sb_item_t;

  sb_item_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  logic clk = 0, rst_n = 0;
  logic [7:0] p_word = 0, q_word = 0;
  logic p_track = 0, logical_mode = 1, gt_in = 0, lt_in = 0;
  logic gt_out, lt_out;

  logic [23:0] ca = 0, cb = 0;
  logic c_mode = 1;
  logic g0, l0, g1, l1, g2, l2;

  always #4 clk = ~clk;

  cascade_mag_cmp #(.W(8)) u_dut (.clk(clk), .rst_n(rst_n), .p_word(p_word), .q_word(q_word),
    .p_track(p_track), .logical_mode(logical_mode), .gt_in(gt_in), .lt_in(lt_in),
    .gt_out(gt_out), .lt_out(lt_out));

  cascade_mag_cmp #(.W(8)) u_c0 (.clk(clk), .rst_n(rst_n), .p_word(ca[7:0]), .q_word(cb[7:0]),
    .p_track(1'b1), .logical_mode(1'b1), .gt_in(1'b0), .lt_in(1'b0), .gt_out(g0), .lt_out(l0));
  cascade_mag_cmp #(.W(8)) u_c1 (.clk(clk), .rst_n(rst_n), .p_word(ca[15:8]), .q_word(cb[15:8]),
    .p_track(1'b1), .logical_mode(1'b1), .gt_in(g0), .lt_in(l0), .gt_out(g1), .lt_out(l1));
  cascade_mag_cmp #(.W(8)) u_c2 (.clk(clk), .rst_n(rst_n), .p_word(ca[23:16]), .q_word(cb[23:16]),
    .p_track(1'b1), .logical_mode(c_mode), .gt_in(g1), .lt_in(l1), .gt_out(g2), .lt_out(l2));

  task automatic slice(input logic [7:0] p, input logic [7:0] q, input logic trk,
                       input logic mode, input logic gi, input logic li,
                       input logic [7:0] p_expect, input string tag);
    sb_item_t it;
    logic above, below;
    @(negedge clk);
    p_word = p; q_word = q; p_track = trk; logical_mode = mode; gt_in = gi; lt_in = li;
    if (mode) begin above = p_expect > q; below = q > p_expect; end
    else begin above = $signed(p_expect) > $signed(q); below = $signed(q) > $signed(p_expect); end
    it.gt = above | (!above && !below && gi);
    it.lt = below | (!above && !below && li);
    it.chain = 0; it.tag = tag;
    #1 sb.push_back(it);
  endtask

  task automatic chain24(input logic [23:0] a, input logic [23:0] b, input logic mode);
    sb_item_t it;
    @(negedge clk);
    ca = a; cb = b; c_mode = mode;
    if (mode) begin it.gt = a > b; it.lt = b > a; end
    else begin it.gt = $signed(a) > $signed(b); it.lt = $signed(b) > $signed(a); end
    it.chain = 1; it.tag = "R9";
    #1 sb.push_back(it);
  endtask

  initial begin : monitor
    sb_item_t it;
    logic ag, al;
    forever begin
      wait (sb.size() != 0);
      it = sb.pop_front();
      ag = it.chain ? g2 : gt_out;
      al = it.chain ? l2 : lt_out;
      checks++;
      if (ag !== it.gt || al !== it.lt) begin
        errors++;
        $display("FAIL %s: gt/lt actual %b%b expected %b%b", it.tag, ag, al, it.gt, it.lt);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [23:0] a, b;
    repeat (3) @(posedge clk);
    // R3: held word is zero after reset; equal to q=0 so cascade passes through
    slice(8'd77, 8'd0, 0, 1, 1, 0, 8'd0, "R3");
    @(negedge clk) rst_n = 1;
    slice(8'd77, 8'd0, 0, 1, 0, 1, 8'd0, "R3");
    // R1: live P used while tracking, captured at the edge
    slice(8'd5, 8'd3, 1, 1, 0, 1, 8'd5, "R1");
    // R2: hold 5 while p_word moves
    slice(8'd200, 8'd5, 0, 1, 1, 0, 8'd5, "R2");
    slice(8'd0, 8'd4, 0, 1, 0, 0, 8'd5, "R2");
    // R4: unsigned order
    slice(8'h7F, 8'h80, 1, 1, 1, 0, 8'h7F, "R4");
    slice(8'hFF, 8'h01, 1, 1, 0, 1, 8'hFF, "R4");
    // R5: every sign-bit pair in arithmetic mode
    slice(8'h7F, 8'h80, 1, 0, 0, 1, 8'h7F, "R5");
    slice(8'h80, 8'h7F, 1, 0, 1, 0, 8'h80, "R5");
    slice(8'h05, 8'hFB, 1, 0, 0, 1, 8'h05, "R5");
    slice(8'hFB, 8'h05, 1, 0, 1, 0, 8'hFB, "R5");
    slice(8'hFF, 8'h80, 1, 0, 0, 1, 8'hFF, "R5");
    slice(8'h01, 8'h02, 1, 0, 1, 0, 8'h01, "R5");
    // R6 / R7: cascade ignored when words differ
    slice(8'd9, 8'd8, 1, 1, 1, 1, 8'd9, "R6");
    slice(8'd8, 8'd9, 1, 1, 1, 1, 8'd8, "R7");
    // R8: every cascade pattern on equal words
    for (int k = 0; k < 4; k++)
      slice(8'h80, 8'h80, 1, k[2], k[1], k[0], 8'h80, "R8");
    for (int k = 0; k < 4; k++)
      slice(8'h3C, 8'h3C, 1, 0, k[1], k[0], 8'h3C, "R8");
    // R9: 24-bit chain
    chain24(24'h000000, 24'h000000, 0);
    chain24(24'h7FFFFF, 24'h800000, 0);
    chain24(24'h7FFFFF, 24'h800000, 1);
    chain24(24'h12AB00, 24'h12AB01, 0);
    for (int n = 0; n < 200; n++) begin
      a = 24'($urandom);
      b = (n % 3 == 0) ? {a[23:8], 8'($urandom)} : 24'($urandom);
      chain24(a, b, n[0]);
    end
    wait (sb.size() == 0);
    #2;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule